// File: doc/BRIEF.md
# SD Host Command Issue Gate

This block decides whether a command that software writes into the SD host command register may actually be launched towards the card. It looks at whether the SD clock is running, whether the card is powered, whether the data lines are free, and what kind of command has just been written. It also reports whether the stored command needs the data lines.

Power is checked against the power control register, but only when one of two signal-select bits in the vendor control word is set; with both clear, the card is treated as powered whatever the power control register says. A command that needs the data lines is held back while the data lines are busy or a transfer is paused. Abort commands are exempt from that block, so that a stuck transfer can always be cancelled.

The decision is made in the cycle that writes the upper byte of the command register. The result is held until the next such write. An accepted command raises a one-cycle launch strobe and sets a command-busy flag, which the command sequencer clears when it has finished. A refused command launches nothing and leaves the busy flag as it was.

Top module: `sdcmd_issue_gate`

## Requirements
- R1: During and directly after reset, `issue_ok`, `issue_go`, `cmd_busy` and `uses_dat` are all 0.
- R2: `uses_dat` is 1 exactly when the stored command has its data-present bit (bit 5) set or its response-type field (bits 1:0) equal to 2'b11 (short response with busy). It follows the stored word after any byte write, one clock edge after the write.
- R3: A command whose upper byte is written while the SD clock enable (`clk_ctrl` bit 2) is 0 is refused.
- R4: When the power-on bit (`pwr_ctrl` bit 0) is 0, a command is refused if `vctrl2` bit 12 or bit 3 is set. With both of those bits clear, power counts as supplied.
- R5: A command that uses the data lines is refused while `dat_inhibit` or `xfer_stopped` is 1, unless its command-type field (bits 7:6) is 2'b11 (abort).
- R6: A command that does not use the data lines is not blocked by `dat_inhibit` or `xfer_stopped`.
- R7: The decision is taken only on a clock edge where `cmd_be[1]` is 1. `issue_ok` then holds its value through input changes and lower-byte-only writes until the next upper-byte write.
- R8: An accepted command gives a single-cycle `issue_go` pulse and sets `cmd_busy`, both one edge after the write. A refused command gives no pulse and leaves `cmd_busy` unchanged.
- R9: `cmd_done` clears `cmd_busy` at the next edge. When it coincides with an accepted write, `cmd_busy` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_ctrl | input | 16 | Clock control register value; bit 2 is SD clock enable |
| pwr_ctrl | input | 8 | Power control register value; bit 0 is power on |
| vctrl2 | input | 32 | Vendor control word; bits 12 and 3 select power-checked signalling |
| dat_inhibit | input | 1 | Data lines busy |
| xfer_stopped | input | 1 | A data transfer is paused |
| cmd_wdata | input | 16 | Write data for the command register |
| cmd_be | input | 2 | Byte enables for the command register write; bit 1 triggers a decision |
| cmd_done | input | 1 | Sequencer has finished the current command |
| issue_ok | output | 1 | Held result of the last decision |
| uses_dat | output | 1 | Stored command needs the data lines |
| issue_go | output | 1 | One-cycle launch strobe for an accepted command |
| cmd_busy | output | 1 | Command in flight |

## Verification
The bench goes after the power bypass: a gate that always required power would refuse with power off and both select bits clear, and a gate that checked only one of the two bits would accept when only the other is set. It sends aborts that use the data lines while the data lines are busy and while a transfer is paused. A gate without the abort exemption would refuse these, and a gate that blocked every command would also refuse plain commands with no data. It changes the inputs between writes and writes only the lower byte, which catches a decision that is not held. It also refuses a command while another is in flight, which catches a busy flag that a refusal clears.

// File: rtl/sdg_pkg.sv
// Package: shared command-register layout for the command issue gate.
// Assumes the standard 16-bit SD host command register layout.
package sdg_pkg;

    typedef enum logic [1:0] {
        RSP_NONE    = 2'b00,
        RSP_LONG    = 2'b01,
        RSP_SHORT   = 2'b10,
        RSP_BUSY    = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CK_NORMAL   = 2'b00,
        CK_SUSPEND  = 2'b01,
        CK_RESUME   = 2'b10,
        CK_ABORT    = 2'b11
    } cmd_kind_e;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic [5:0] index;
        cmd_kind_e  kind;
        logic       has_data;
        logic       idx_chk;
        logic       crc_chk;
        logic       spare_lo;
        rsp_kind_e  rsp;
    } cmd_word_t;

    localparam int CMD_W = $bits(cmd_word_t);

endpackage

// File: rtl/sdg_supply_check.sv
// Module: sdg_supply_check
// Says whether the card has a running SD clock and counts as powered.
// Assumes the control values are stable register outputs.
// Power is only checked when one of the two signal-select bits is set.
module sdg_supply_check #(
    parameter int CLK_CTRL_W    = 16,
    parameter int PWR_CTRL_W    = 8,
    parameter int VCTRL_W       = 32,
    parameter int SDCLK_EN_BIT  = 2,
    parameter int INTCLK_EN_BIT = 0,
    parameter int PWR_ON_BIT    = 0,
    parameter int SEL_OUT_BIT   = 12,
    parameter int SEL_IN_BIT    = 3,
    parameter bit REQ_INTCLK    = 1'b0
) (
    input  logic [CLK_CTRL_W-1:0] clk_ctrl,
    input  logic [PWR_CTRL_W-1:0] pwr_ctrl,
    input  logic [VCTRL_W-1:0]    vctrl2,
    output logic                  supply_ok
);

    logic clock_on;
    logic power_checked;
    logic power_ok;

    // Pick the clock-on rule: SD clock alone, or SD clock plus internal clock.
    generate
        if (REQ_INTCLK) begin : g_clk_both
            assign clock_on = clk_ctrl[SDCLK_EN_BIT] & clk_ctrl[INTCLK_EN_BIT];
        end else begin : g_clk_sd
            assign clock_on = clk_ctrl[SDCLK_EN_BIT];
        end
    endgenerate

    // Decide whether power matters and, if so, whether it is on.
    always_comb begin
        power_checked = vctrl2[SEL_OUT_BIT] | vctrl2[SEL_IN_BIT];
        power_ok      = pwr_ctrl[PWR_ON_BIT] | ~power_checked;
        supply_ok     = clock_on & power_ok;
    end

endmodule

// File: rtl/sdg_cmd_classify.sv
// Module: sdg_cmd_classify
// Decodes a command word into "needs data lines" and "is abort".
// Assumes the word follows sdg_pkg::cmd_word_t.
module sdg_cmd_classify
    import sdg_pkg::*;
(
    input  cmd_word_t cmd,
    output logic      needs_dat,
    output logic      is_abort
);

    // Classify the command from its data-present, response and type fields.
    always_comb begin
        needs_dat = cmd.has_data | (cmd.rsp == RSP_BUSY);
        is_abort  = (cmd.kind == CK_ABORT);
    end

endmodule

// File: rtl/sdg_issue_hold.sv
// Module: sdg_issue_hold
// Holds the command register, the latched decision, the launch strobe
// and the busy flag. Assumes `allow` was computed from `merged`.
module sdg_issue_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   be,
    input  logic         allow,
    input  logic         done,
    output logic [W-1:0] merged,
    output logic [W-1:0] cmd_q,
    output logic         ok_q,
    output logic         go_q,
    output logic         busy_q
);

    localparam int HALF = W / 2;

    logic accept;

    // Combine the write data with the stored bytes under the byte enables.
    always_comb begin
        merged = cmd_q;
        if (be[0]) merged[HALF-1:0] = wdata[HALF-1:0];
        if (be[1]) merged[W-1:HALF] = wdata[W-1:HALF];
        accept = be[1] & allow;
    end

    // Store the command word on any byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (|be)
            cmd_q <= merged;
    end

    // Latch the decision on an upper-byte write and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ok_q <= 1'b0;
        else if (be[1])
            ok_q <= allow;
    end

    // Strobe once per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_q <= 1'b0;
        else
            go_q <= accept;
    end

    // Busy is set by an accepted command and cleared by done; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (accept)
            busy_q <= 1'b1;
        else if (done)
            busy_q <= 1'b0;
    end

endmodule

// File: rtl/sdcmd_issue_gate.sv
// Module: sdcmd_issue_gate
// Top of the command issue gate: checks clock and power, classifies the
// command being written, applies the data-busy rule with the abort
// exemption, and registers the outcome. Assumes register values arrive
// already decoded from the host bus and stay stable in the write cycle.
module sdcmd_issue_gate
    import sdg_pkg::*;
#(
    parameter int CLK_CTRL_W    = 16,
    parameter int PWR_CTRL_W    = 8,
    parameter int VCTRL_W       = 32,
    parameter int SDCLK_EN_BIT  = 2,
    parameter int INTCLK_EN_BIT = 0,
    parameter int PWR_ON_BIT    = 0,
    parameter int SEL_OUT_BIT   = 12,
    parameter int SEL_IN_BIT    = 3,
    parameter bit REQ_INTCLK    = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CLK_CTRL_W-1:0] clk_ctrl,
    input  logic [PWR_CTRL_W-1:0] pwr_ctrl,
    input  logic [VCTRL_W-1:0]    vctrl2,
    input  logic                  dat_inhibit,
    input  logic                  xfer_stopped,
    input  logic [15:0]           cmd_wdata,
    input  logic [1:0]            cmd_be,
    input  logic                  cmd_done,
    output logic                  issue_ok,
    output logic                  uses_dat,
    output logic                  issue_go,
    output logic                  cmd_busy
);

    logic             supply_ok;
    logic [CMD_W-1:0] merged;
    logic [CMD_W-1:0] cmd_q;
    logic             nxt_needs_dat;
    logic             nxt_abort;
    logic             cur_abort;
    logic             dat_blocked;
    logic             allow;

    sdg_supply_check #(
        .CLK_CTRL_W    (CLK_CTRL_W),
        .PWR_CTRL_W    (PWR_CTRL_W),
        .VCTRL_W       (VCTRL_W),
        .SDCLK_EN_BIT  (SDCLK_EN_BIT),
        .INTCLK_EN_BIT (INTCLK_EN_BIT),
        .PWR_ON_BIT    (PWR_ON_BIT),
        .SEL_OUT_BIT   (SEL_OUT_BIT),
        .SEL_IN_BIT    (SEL_IN_BIT),
        .REQ_INTCLK    (REQ_INTCLK)
    ) u_supply (
        .clk_ctrl  (clk_ctrl),
        .pwr_ctrl  (pwr_ctrl),
        .vctrl2    (vctrl2),
        .supply_ok (supply_ok)
    );

    // Classifier for the word being written (feeds the decision).
    sdg_cmd_classify u_cls_next (
        .cmd       (cmd_word_t'(merged)),
        .needs_dat (nxt_needs_dat),
        .is_abort  (nxt_abort)
    );

    // Classifier for the stored word (feeds the uses_dat output).
    sdg_cmd_classify u_cls_cur (
        .cmd       (cmd_word_t'(cmd_q)),
        .needs_dat (uses_dat),
        .is_abort  (cur_abort)
    );

    // Apply the data-line rule and combine it with the supply check.
    always_comb begin
        dat_blocked = nxt_needs_dat & (dat_inhibit | xfer_stopped) & ~nxt_abort;
        allow       = supply_ok & ~dat_blocked;
    end

    sdg_issue_hold #(
        .W (CMD_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (cmd_wdata),
        .be     (cmd_be),
        .allow  (allow),
        .done   (cmd_done),
        .merged (merged),
        .cmd_q  (cmd_q),
        .ok_q   (issue_ok),
        .go_q   (issue_go),
        .busy_q (cmd_busy)
    );

    // The stored abort flag is not used at the ports.
    logic unused_ok;
    assign unused_ok = cur_abort;

endmodule

// File: rtl/sdcmd_issue_gate_chk.sv
// Module: sdcmd_issue_gate_chk
// Checker for the command issue gate, attached to the top module by bind.
module sdcmd_issue_gate_chk #(
    parameter int CLK_CTRL_W   = 16,
    parameter int SDCLK_EN_BIT = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CLK_CTRL_W-1:0] clk_ctrl,
    input logic                  dat_inhibit,
    input logic                  xfer_stopped,
    input logic [15:0]           cmd_wdata,
    input logic [1:0]            cmd_be,
    input logic                  cmd_done,
    input logic                  issue_ok,
    input logic                  issue_go,
    input logic                  cmd_busy
);

    // R3
    clk_off_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_be[1] && !clk_ctrl[SDCLK_EN_BIT]) |=> !issue_ok);

    // R5
    dat_busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_be == 2'b11 && (dat_inhibit || xfer_stopped) && cmd_wdata[5]
         && cmd_wdata[7:6] != 2'b11) |=> !issue_ok);

    // R7
    decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cmd_be[1])) |-> $stable(issue_ok));

    // R8
    go_implies_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> (issue_ok && cmd_busy));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> issue_go);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_done) && !issue_go) |-> !cmd_busy);

endmodule

bind sdcmd_issue_gate sdcmd_issue_gate_chk #(
    .CLK_CTRL_W   (CLK_CTRL_W),
    .SDCLK_EN_BIT (SDCLK_EN_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_ctrl     (clk_ctrl),
    .dat_inhibit  (dat_inhibit),
    .xfer_stopped (xfer_stopped),
    .cmd_wdata    (cmd_wdata),
    .cmd_be       (cmd_be),
    .cmd_done     (cmd_done),
    .issue_ok     (issue_ok),
    .issue_go     (issue_go),
    .cmd_busy     (cmd_busy)
);

// File: tb/sdcmd_issue_gate_bench.sv
// Bench for sdcmd_issue_gate: a vector table walked by one loop, then
// directed tests for reset, holding, busy handling and byte writes.
module sdcmd_issue_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] clk_ctrl;
    logic [7:0]  pwr_ctrl;
    logic [31:0] vctrl2;
    logic        dat_inhibit;
    logic        xfer_stopped;
    logic [15:0] cmd_wdata;
    logic [1:0]  cmd_be;
    logic        cmd_done;
    logic        issue_ok;
    logic        uses_dat;
    logic        issue_go;
    logic        cmd_busy;

    int tests  = 0;
    int failed = 0;

    always #5 clk = ~clk;

    sdcmd_issue_gate u_sdcmd_issue_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_ctrl     (clk_ctrl),
        .pwr_ctrl     (pwr_ctrl),
        .vctrl2       (vctrl2),
        .dat_inhibit  (dat_inhibit),
        .xfer_stopped (xfer_stopped),
        .cmd_wdata    (cmd_wdata),
        .cmd_be       (cmd_be),
        .cmd_done     (cmd_done),
        .issue_ok     (issue_ok),
        .uses_dat     (uses_dat),
        .issue_go     (issue_go),
        .cmd_busy     (cmd_busy)
    );

    // Vector: {exp_uses, exp_ok, {stopped, inhibit, sel3, sel12, pwr, sdclk}, cmd}
    // Commands: 0802 plain short response; 113A read with data;
    // 071B busy response; 0CDB abort with busy; 0CE2 abort with data.
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b1, 6'b000011, 16'h0802},  // R3 R4 normal accept
        {1'b0, 1'b0, 6'b000010, 16'h0802},  // R3 clock off
        {1'b0, 1'b1, 6'b000001, 16'h0802},  // R4 power off, bypass
        {1'b0, 1'b0, 6'b000101, 16'h0802},  // R4 power off, bit 12
        {1'b0, 1'b0, 6'b001001, 16'h0802},  // R4 power off, bit 3
        {1'b0, 1'b1, 6'b001111, 16'h0802},  // R4 power on, both bits
        {1'b1, 1'b0, 6'b010011, 16'h113A},  // R5 inhibit, data
        {1'b1, 1'b0, 6'b100011, 16'h071B},  // R5 stopped, busy rsp
        {1'b1, 1'b1, 6'b110011, 16'h0CDB},  // R5 abort exempt
        {1'b0, 1'b1, 6'b110011, 16'h0802},  // R6 no data, not blocked
        {1'b1, 1'b1, 6'b000011, 16'h113A},  // R2 data command accepted
        {1'b1, 1'b0, 6'b011100, 16'h0CE2}   // R3 clock off beats abort
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_env(input logic [5:0] e);
        clk_ctrl     = {13'd0, e[0], 2'b00};
        pwr_ctrl     = {7'd0, e[1]};
        vctrl2       = 32'd0;
        vctrl2[12]   = e[2];
        vctrl2[3]    = e[3];
        dat_inhibit  = e[4];
        xfer_stopped = e[5];
    endtask

    // Write at a negative edge, let one rising edge take it, return at the next negative edge.
    task automatic write_cmd(input logic [1:0] be, input logic [15:0] d, input logic done);
        cmd_be    = be;
        cmd_wdata = d;
        cmd_done  = done;
        @(negedge clk);
        cmd_be    = 2'b00;
        cmd_done  = 1'b0;
    endtask

    task automatic idle(input logic done);
        cmd_done = done;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        apply_env(6'b000011);
        cmd_wdata = 16'h0802;
        cmd_be    = 2'b11;
        cmd_done  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held, even with a write pending
        chk("R1 ok", {15'd0, issue_ok}, 16'd0);
        chk("R1 go", {15'd0, issue_go}, 16'd0);
        chk("R1 busy", {15'd0, cmd_busy}, 16'd0);
        chk("R1 uses", {15'd0, uses_dat}, 16'd0);
        cmd_be = 2'b00;
        rst_n  = 1'b1;
        @(negedge clk);
        chk("R1 after", {12'd0, issue_ok, issue_go, cmd_busy, uses_dat}, 16'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            apply_env(VEC[i][21:16]);
            write_cmd(2'b11, VEC[i][15:0], 1'b0);
            chk($sformatf("R3-R6 vec%0d ok", i), {15'd0, issue_ok}, {15'd0, VEC[i][22]});
            chk($sformatf("R2 vec%0d uses", i), {15'd0, uses_dat}, {15'd0, VEC[i][23]});
            chk($sformatf("R8 vec%0d go", i), {15'd0, issue_go}, {15'd0, VEC[i][22]});
            chk($sformatf("R8 vec%0d busy", i), {15'd0, cmd_busy}, {15'd0, VEC[i][22]});
            idle(1'b1);
            chk($sformatf("R8 vec%0d go once", i), {15'd0, issue_go}, 16'd0);
            chk($sformatf("R9 vec%0d cleared", i), {15'd0, cmd_busy}, 16'd0);
        end

        // R7: accepted decision held while inputs turn hostile
        apply_env(6'b000011);
        write_cmd(2'b11, 16'h0802, 1'b0);
        chk("R7 accepted", {15'd0, issue_ok}, 16'd1);
        apply_env(6'b111100);
        idle(1'b0);
        idle(1'b0);
        chk("R7 held", {15'd0, issue_ok}, 16'd1);
        // R2 R7: lower-byte write changes uses_dat but not the decision
        write_cmd(2'b01, 16'h0020, 1'b0);
        chk("R2 low byte uses", {15'd0, uses_dat}, 16'd1);
        chk("R7 low byte ok", {15'd0, issue_ok}, 16'd1);
        chk("R7 low byte go", {15'd0, issue_go}, 16'd0);

        // R8: refused command while busy leaves busy set
        chk("R8 still busy", {15'd0, cmd_busy}, 16'd1);
        write_cmd(2'b10, 16'h0500, 1'b0);
        chk("R8 refused ok", {15'd0, issue_ok}, 16'd0);
        chk("R8 refused go", {15'd0, issue_go}, 16'd0);
        chk("R8 refused busy", {15'd0, cmd_busy}, 16'd1);

        // R9: done together with an accepted write keeps busy set
        apply_env(6'b000011);
        write_cmd(2'b11, 16'h0802, 1'b1);
        chk("R9 same-cycle busy", {15'd0, cmd_busy}, 16'd1);
        chk("R9 same-cycle go", {15'd0, issue_go}, 16'd1);
        idle(1'b1);
        chk("R9 done clears", {15'd0, cmd_busy}, 16'd0);

        // R5 R6: upper-only write reuses stored low byte (data present set)
        write_cmd(2'b01, 16'h0020, 1'b0);
        apply_env(6'b010011);
        write_cmd(2'b10, 16'h1100, 1'b0);
        chk("R5 stored data bit blocks", {15'd0, issue_ok}, 16'd0);
        write_cmd(2'b11, 16'h0C00, 1'b0);
        chk("R6 no-response command passes", {15'd0, issue_ok}, 16'd1);
        chk("R2 uses clear", {15'd0, uses_dat}, 16'd0);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule